// File: doc/BRIEF.md
# Load-to-use stall controller

This block sits beside the decode stage of a five-stage in-order pipeline. It watches the instruction now in the execute stage and the one now being decoded. A stall is needed when the execute-stage instruction is a load and the decoded instruction reads the register that the load will write. In that case the block freezes the program counter and the fetch/decode register for one clock. In the same clock it turns the decoded instruction's entry into the execute-stage control register into a bubble. On the next cycle the dependent instruction decodes again. The load's result then reaches it through the memory/writeback forwarding path, which is outside this block.

The hazard outputs are combinational from the current stage contents. They act on the registers at the next rising edge. A small model of the program counter, the fetch/decode register and the execute-stage control register is part of the block, so that the effect of a stall can be seen at the ports. The load flag marks a load because no other instruction kind sets it. A load that targets register 0 never stalls, since that register is never written.

Top module: `lu_stall_unit`

## Requirements
- R1: While `rst_n` is low, `pc_q`, `ifid_q` and `ex_ctrl_q` are all zero.
- R2: A stall (`bubble`=1) is raised when `ex_load` is 1, `ex_dst` is non-zero and `ex_dst` equals `id_src_a`.
- R3: A stall is raised when `ex_load` is 1, `ex_dst` is non-zero and `ex_dst` equals `id_src_b`.
- R4: When `ex_load` is 0, no stall is raised, whatever the register numbers are.
- R5: When `ex_dst` is 0, no stall is raised, even if a source is also 0 and `ex_load` is 1.
- R6: With no stall, `pc_we`=1, `ifid_we`=1 and `bubble`=0. With a stall, `pc_we`=0, `ifid_we`=0 and `bubble`=1, in the same cycle as the inputs.
- R7: At a rising edge, `pc_q` advances by `PC_STEP` (4) when `pc_we` is 1 and keeps its value when `pc_we` is 0.
- R8: At a rising edge, `ifid_q` takes `fetch_word` when `ifid_we` is 1 and keeps its value when `ifid_we` is 0.
- R9: At a rising edge, `ex_ctrl_q` takes `id_ctrl` when `bubble` is 0 and becomes 4'b0000 when `bubble` is 1. The bit layout is {reg write [3], mem read [2], mem write [1], branch [0]}.
- R10: A load followed by a dependent instruction stalls for exactly one cycle. On the next cycle the execute stage holds the bubble (`ex_load`=0), and the dependent instruction then proceeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronous to clk |
| ex_load | input | 1 | Execute-stage instruction is a load |
| ex_dst | input | REG_W | Destination register of the execute-stage instruction |
| id_src_a | input | REG_W | First source register of the decoded instruction |
| id_src_b | input | REG_W | Second source register of the decoded instruction |
| id_ctrl | input | 4 | Decoded control bits {reg write, mem read, mem write, branch} |
| fetch_word | input | INSTR_W | Instruction word fetched at `pc_q` |
| pc_we | output | 1 | Program counter update enable |
| ifid_we | output | 1 | Fetch/decode register update enable |
| bubble | output | 1 | Zero the controls entering the execute stage |
| pc_q | output | PC_W | Program counter |
| ifid_q | output | INSTR_W | Fetch/decode instruction register |
| ex_ctrl_q | output | 4 | Execute-stage control register |

## Verification
The properties assume that every input is a known value from the first edge after reset. They also assume that the register numbers are only meaningful together with the load flag, so a stale `ex_dst` with `ex_load` low must never stall. The stimulus changes inputs only at falling edges and gives every field a defined value in each cycle. It also drives the execute stage the way a real pipeline would after a stall: the bubble follows the load, with the load flag cleared.

// File: rtl/lu_pkg.sv
package lu_pkg;
  // Control bits carried into the execute stage; order fixes the port layout.
  typedef struct packed {
    logic reg_wr;
    logic mem_rd;
    logic mem_wr;
    logic br;
  } ex_ctrl_t;

  localparam int CTRL_W = $bits(ex_ctrl_t);
endpackage

// File: rtl/lu_match.sv
module lu_match #(
  parameter int REG_W = 5,
  parameter int N_SRC = 2
) (
  input  logic                   ld,
  input  logic [REG_W-1:0]       dst,
  input  logic [N_SRC*REG_W-1:0] srcs,
  output logic                   hit
);
  logic [N_SRC-1:0] eq;

  for (genvar g = 0; g < N_SRC; g++) begin : g_cmp
    assign eq[g] = (srcs[g*REG_W +: REG_W] == dst);
  end

  // Register 0 is never written, so a load into it carries no dependence.
  assign hit = ld && (dst != '0) && (|eq);
endmodule

// File: rtl/lu_front.sv
module lu_front #(
  parameter int PC_W    = 32,
  parameter int INSTR_W = 32,
  parameter int PC_STEP = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pc_en,
  input  logic               ir_en,
  input  logic [INSTR_W-1:0] fetch_word,
  output logic [PC_W-1:0]    pc_q,
  output logic [INSTR_W-1:0] ir_q
);
  logic [PC_W-1:0] pc_d;

  always_comb begin
    pc_d = pc_q + PC_W'(PC_STEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else if (pc_en) begin
      pc_q <= pc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_q <= '0;
    end else if (ir_en) begin
      ir_q <= fetch_word;
    end
  end
endmodule

// File: rtl/lu_ctrl_reg.sv
module lu_ctrl_reg
  import lu_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     zero,
  input  ex_ctrl_t d,
  output ex_ctrl_t q
);
  ex_ctrl_t q_d;

  always_comb begin
    q_d = zero ? ex_ctrl_t'('0) : d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= q_d;
    end
  end
endmodule

// File: rtl/lu_stall_unit.sv
module lu_stall_unit
  import lu_pkg::*;
#(
  parameter int REG_W   = 5,
  parameter int INSTR_W = 32,
  parameter int PC_W    = 32,
  parameter int PC_STEP = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ex_load,
  input  logic [REG_W-1:0]   ex_dst,
  input  logic [REG_W-1:0]   id_src_a,
  input  logic [REG_W-1:0]   id_src_b,
  input  logic [CTRL_W-1:0]  id_ctrl,
  input  logic [INSTR_W-1:0] fetch_word,
  output logic               pc_we,
  output logic               ifid_we,
  output logic               bubble,
  output logic [PC_W-1:0]    pc_q,
  output logic [INSTR_W-1:0] ifid_q,
  output logic [CTRL_W-1:0]  ex_ctrl_q
);
  localparam int N_SRC = 2;

  logic [N_SRC*REG_W-1:0] srcs;
  logic                   hazard;
  ex_ctrl_t               ctrl_d;
  ex_ctrl_t               ctrl_q;

  assign srcs = {id_src_b, id_src_a};

  lu_match #(.REG_W(REG_W), .N_SRC(N_SRC)) u_match (
    .ld   (ex_load),
    .dst  (ex_dst),
    .srcs (srcs),
    .hit  (hazard)
  );

  assign pc_we   = !hazard;
  assign ifid_we = !hazard;
  assign bubble  = hazard;

  lu_front #(.PC_W(PC_W), .INSTR_W(INSTR_W), .PC_STEP(PC_STEP)) u_front (
    .clk        (clk),
    .rst_n      (rst_n),
    .pc_en      (pc_we),
    .ir_en      (ifid_we),
    .fetch_word (fetch_word),
    .pc_q       (pc_q),
    .ir_q       (ifid_q)
  );

  assign ctrl_d = ex_ctrl_t'(id_ctrl);

  lu_ctrl_reg u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .zero  (bubble),
    .d     (ctrl_d),
    .q     (ctrl_q)
  );

  assign ex_ctrl_q = ctrl_q;
endmodule

// File: rtl/lu_stall_chk.sv
module lu_stall_chk #(
  parameter int REG_W   = 5,
  parameter int INSTR_W = 32,
  parameter int PC_W    = 32,
  parameter int PC_STEP = 4,
  parameter int CTRL_W  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ex_load,
  input logic [REG_W-1:0]   ex_dst,
  input logic [REG_W-1:0]   id_src_a,
  input logic [REG_W-1:0]   id_src_b,
  input logic [CTRL_W-1:0]  id_ctrl,
  input logic [INSTR_W-1:0] fetch_word,
  input logic               pc_we,
  input logic               ifid_we,
  input logic               bubble,
  input logic [PC_W-1:0]    pc_q,
  input logic [INSTR_W-1:0] ifid_q,
  input logic [CTRL_W-1:0]  ex_ctrl_q
);
  // R2
  src_a_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_load && ex_dst != '0 && ex_dst == id_src_a) |-> bubble);
  // R3
  src_b_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_load && ex_dst != '0 && ex_dst == id_src_b) |-> bubble);
  // R4
  no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_load |-> (pc_we && ifid_we && !bubble));
  // R5
  zero_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_dst == '0) |-> !bubble);
  // R6
  enables_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_we == ifid_we) && (pc_we != bubble));
  // R7
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_we |=> $stable(pc_q));
  // R7
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |=> (pc_q == $past(pc_q) + PC_W'(PC_STEP)));
  // R8
  ir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ifid_we |=> $stable(ifid_q));
  // R8
  ir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ifid_we |=> (ifid_q == $past(fetch_word)));
  // R9
  bubble_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bubble |=> (ex_ctrl_q == '0));
  // R9
  ctrl_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bubble |=> (ex_ctrl_q == $past(id_ctrl)));
endmodule

bind lu_stall_unit lu_stall_chk #(
  .REG_W(REG_W), .INSTR_W(INSTR_W), .PC_W(PC_W), .PC_STEP(PC_STEP), .CTRL_W(lu_pkg::CTRL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ex_load(ex_load), .ex_dst(ex_dst),
  .id_src_a(id_src_a), .id_src_b(id_src_b), .id_ctrl(id_ctrl),
  .fetch_word(fetch_word), .pc_we(pc_we), .ifid_we(ifid_we),
  .bubble(bubble), .pc_q(pc_q), .ifid_q(ifid_q), .ex_ctrl_q(ex_ctrl_q)
);

// File: tb/tb_lu_stall_unit.sv
`timescale 1ns/1ps
module tb_lu_stall_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ex_load = 1'b0;
  logic [4:0]  ex_dst = '0;
  logic [4:0]  id_src_a = '0;
  logic [4:0]  id_src_b = '0;
  logic [3:0]  id_ctrl = '0;
  logic [31:0] fetch_word = '0;
  logic        pc_we, ifid_we, bubble;
  logic [31:0] pc_q, ifid_q;
  logic [3:0]  ex_ctrl_q;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [31:0] pc_exp, ir_exp;
  logic [3:0]  ctl_exp;

  always #10 clk = ~clk;

  lu_stall_unit dut (
    .clk(clk), .rst_n(rst_n), .ex_load(ex_load), .ex_dst(ex_dst),
    .id_src_a(id_src_a), .id_src_b(id_src_b), .id_ctrl(id_ctrl),
    .fetch_word(fetch_word), .pc_we(pc_we), .ifid_we(ifid_we),
    .bubble(bubble), .pc_q(pc_q), .ifid_q(ifid_q), .ex_ctrl_q(ex_ctrl_q)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  // Called at a falling edge: drive one cycle, check enables, then registers.
  task automatic cycle(input string req, input logic ld, input logic [4:0] dst,
                       input logic [4:0] a, input logic [4:0] b,
                       input logic [3:0] ctl, input logic [31:0] word,
                       input bit exp_stall);
    ex_load = ld; ex_dst = dst; id_src_a = a; id_src_b = b;
    id_ctrl = ctl; fetch_word = word;
    #2;
    chk(req, "bubble", {31'b0, bubble}, {31'b0, exp_stall});
    chk("R6", "pc_we", {31'b0, pc_we}, {31'b0, !exp_stall});
    chk("R6", "ifid_we", {31'b0, ifid_we}, {31'b0, !exp_stall});
    if (!exp_stall) begin
      pc_exp = pc_exp + 32'd4;
      ir_exp = word;
      ctl_exp = ctl;
    end else begin
      ctl_exp = 4'b0000;
    end
    @(posedge clk);
    #2;
    chk("R7", "pc_q", pc_q, pc_exp);
    chk("R8", "ifid_q", ifid_q, ir_exp);
    chk("R9", "ex_ctrl_q", {28'b0, ex_ctrl_q}, {28'b0, ctl_exp});
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    #5;
    chk("R1", "pc_q", pc_q, 32'h0);
    chk("R1", "ifid_q", ifid_q, 32'h0);
    chk("R1", "ex_ctrl_q", {28'b0, ex_ctrl_q}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    pc_exp = '0; ir_exp = '0; ctl_exp = '0;
  endtask

  task automatic t_src_a();
    cycle("R2", 1'b1, 5'd7, 5'd7, 5'd3, 4'b1000, 32'hA000_0001, 1'b1);
    cycle("R2", 1'b1, 5'd31, 5'd31, 5'd0, 4'b1100, 32'hA000_0002, 1'b1);
  endtask

  task automatic t_src_b();
    cycle("R3", 1'b1, 5'd9, 5'd2, 5'd9, 4'b0010, 32'hB000_0001, 1'b1);
    cycle("R3", 1'b1, 5'd1, 5'd1, 5'd1, 4'b1001, 32'hB000_0002, 1'b1);
  endtask

  task automatic t_no_load();
    cycle("R4", 1'b0, 5'd7, 5'd7, 5'd7, 4'b1111, 32'hC000_0001, 1'b0);
    cycle("R4", 1'b1, 5'd6, 5'd5, 5'd4, 4'b0101, 32'hC000_0002, 1'b0);
  endtask

  task automatic t_zero_dst();
    cycle("R5", 1'b1, 5'd0, 5'd0, 5'd0, 4'b1010, 32'hD000_0001, 1'b0);
    cycle("R5", 1'b1, 5'd0, 5'd0, 5'd12, 4'b0110, 32'hD000_0002, 1'b0);
  endtask

  task automatic t_load_use();
    // load in EX, dependent decoded: one stall, then bubble in EX, then go
    cycle("R10", 1'b1, 5'd8, 5'd4, 5'd8, 4'b1000, 32'hE000_0001, 1'b1);
    cycle("R10", 1'b0, 5'd0, 5'd4, 5'd8, 4'b1000, 32'hE000_0002, 1'b0);
    cycle("R10", 1'b0, 5'd8, 5'd9, 5'd10, 4'b1100, 32'hE000_0003, 1'b0);
  endtask

  initial begin
    t_reset();
    t_no_load();
    t_src_a();
    t_src_b();
    t_zero_dst();
    t_load_use();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule